// File: doc/BRIEF.md
# Asynchronous Serial Port with Flow Control

This block is a transmitter and receiver pair for asynchronous serial frames. The host side works one word at a time. A transmit word goes in through a valid/ready handshake. A received word is held on `rx_data` with `rx_valid` and three error flags until the host pulses `rx_rd`. Each frame has a start bit, 8 or 9 data bits, an optional parity bit and one or two stop bits. The frame shape is chosen at run time through configuration inputs.

Bit timing comes from a tick at sixteen times the bit rate. The tick is produced by an internal integer divider, or it is taken from an external tick input. Flow control uses two active-low signals. `cts_n` is checked before each new frame starts. `rts_n` tells the far end whether a word can be accepted.

In full-duplex mode the block uses separate `txd` and `rxd` pins. In half-duplex mode it drives one shared line through `sio_o`/`sio_oe` only while a frame is being sent. The receiver then listens to `sio_i` and ignores `rxd`.

Top module: `serial_link_fc`

## Requirements
- R1: After reset `tx_ready`=1, `tx_done`=1, `rx_valid`=0, `rts_n`=0, `txd`=1 and `sio_oe`=0.
- R2: A frame is sent and received in this order: a low start bit, then the data bits least significant first (8 bits, or 9 when `cfg_nine`=1), then a parity bit when `cfg_par_en`=1, then one stop bit (or two when `cfg_two_stop`=1) at high level. Each bit lasts 16 ticks and the idle line is high. In 8-bit mode `rx_data[8]` reads 0.
- R3: With `cfg_par_odd`=0 the parity bit makes the count of ones in data plus parity even, and with `cfg_par_odd`=1 it makes the count odd. A received word whose parity bit disagrees sets `rx_perr`.
- R4: A new frame starts only while the synchronised `cts_n` is low. While `cts_n` is high the waiting word is held back, but a frame already started runs to its last stop bit.
- R5: `rts_n` is 0 while no unread word is held. It is 1 from word completion until the host pulses `rx_rd`, and the pulse clears `rx_valid` and all three flags.
- R6: With `cfg_half`=1, `sio_oe` is 1 only while a frame is being sent, `sio_o` carries that frame, and `txd` stays 1.
- R7: With `cfg_half`=1 the receiver takes its input from `sio_i`, including the block's own frames, and `rxd` has no effect.
- R8: A low level on the receive input must still be low 8 ticks after it began to be taken as a start bit. A shorter low pulse produces no word.
- R9: A low level where the first stop bit is sampled sets `rx_ferr` for that word.
- R10: A word that completes while the previous one is unread sets `rx_ovr`. The old word and its flags stay on the outputs.
- R11: `tx_ready` returns to 1 once an accepted word has moved into the shifter, which is one cycle after acceptance when CTS allows. `tx_done` is 0 from acceptance until the last stop bit has ended.
- R12: With `cfg_ext_tick`=0 a tick occurs every `cfg_div`+1 clocks. With `cfg_ext_tick`=1 each clock with `ext_tick` high is a tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_nine | input | 1 | 1: 9 data bits, 0: 8 data bits |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1: odd parity, 0: even parity |
| cfg_two_stop | input | 1 | 1: two stop bits |
| cfg_half | input | 1 | Single shared line mode |
| cfg_ext_tick | input | 1 | Use `ext_tick` as the oversampling tick |
| cfg_div | input | DIV_W | Internal divider, tick period is cfg_div+1 clocks |
| ext_tick | input | 1 | External oversampling tick |
| tx_data | input | 9 | Word to send |
| tx_valid | input | 1 | Transmit word offered |
| tx_ready | output | 1 | Holding register empty |
| tx_done | output | 1 | Nothing waiting and nothing being sent |
| rx_data | output | 9 | Received word |
| rx_valid | output | 1 | Unread word held |
| rx_rd | input | 1 | Host takes the held word |
| rx_perr | output | 1 | Parity error on held word |
| rx_ferr | output | 1 | Framing error on held word |
| rx_ovr | output | 1 | A word was lost while this one was unread |
| txd | output | 1 | Transmit pin (full duplex) |
| rxd | input | 1 | Receive pin (full duplex) |
| sio_o | output | 1 | Shared line drive value |
| sio_oe | output | 1 | Shared line drive enable |
| sio_i | input | 1 | Shared line level |
| cts_n | input | 1 | Clear to send, active low |
| rts_n | output | 1 | Request to send, active low |

## Verification
A table of frame shapes exercises the main function. It covers 8 and 9 data bits, no parity, even parity and odd parity, and one or two stop bits, with data chosen so that even and odd parity give different bits. Each entry is sent through the transmitter, where the captured bit stream shows any error in bit order, parity sense or stop length. The same entry is driven into the receiver, where a flipped parity bit or a low stop bit must raise only the matching flag. Directed patterns then separate the cases that the table cannot reach. A CTS level held high before a frame is told apart from one raised in mid-frame. A short glitch is told apart from a true start bit. A second word arriving before the read shows the overrun behaviour. A frame on `rxd` and a frame on the shared line in half-duplex mode show which input the receiver uses. Both tick sources are run at a slower bit rate.

// File: rtl/serial_link_fc.sv
module serial_link_fc #(
  parameter int DIV_W = 16,
  parameter int OVS   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_nine,
  input  logic             cfg_par_en,
  input  logic             cfg_par_odd,
  input  logic             cfg_two_stop,
  input  logic             cfg_half,
  input  logic             cfg_ext_tick,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic             ext_tick,
  input  logic [8:0]       tx_data,
  input  logic             tx_valid,
  output logic             tx_ready,
  output logic             tx_done,
  output logic [8:0]       rx_data,
  output logic             rx_valid,
  input  logic             rx_rd,
  output logic             rx_perr,
  output logic             rx_ferr,
  output logic             rx_ovr,
  output logic             txd,
  input  logic             rxd,
  output logic             sio_o,
  output logic             sio_oe,
  input  logic             sio_i,
  input  logic             cts_n,
  output logic             rts_n
);
  localparam int CW = $clog2(OVS);
  localparam logic [CW-1:0] LAST = CW'(OVS - 1);
  localparam logic [CW-1:0] HALF = CW'(OVS / 2 - 1);

  typedef enum logic [2:0] {R_IDLE, R_START, R_DATA, R_PAR, R_STOP} rx_st_e;

  logic [DIV_W-1:0] dcnt;
  logic tick;
  logic cts_m, cts_s, rx_m, rx_s;

  assign tick = cfg_ext_tick ? ext_tick : (dcnt == cfg_div);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) dcnt <= '0;
    else if (cfg_ext_tick || dcnt == cfg_div) dcnt <= '0;
    else dcnt <= dcnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cts_m <= 1'b1; cts_s <= 1'b1; rx_m <= 1'b1; rx_s <= 1'b1;
    end else begin
      cts_m <= cts_n; cts_s <= cts_m;
      rx_m  <= cfg_half ? sio_i : rxd; rx_s <= rx_m;
    end

  // transmitter
  logic [8:0]    hold;
  logic          hold_full, busy, load, tbit, tpar;
  logic [12:0]   tsh, tfrm;
  logic [3:0]    tleft, tlen;
  logic [CW-1:0] tcnt;
  logic [8:0]    tword;

  assign tword = cfg_nine ? hold : {1'b0, hold[7:0]};
  assign tpar  = (^tword) ^ cfg_par_odd;
  assign tlen  = 4'd10 + {3'd0, cfg_nine} + {3'd0, cfg_par_en} + {3'd0, cfg_two_stop};
  assign load  = hold_full && !busy && !cts_s;

  always_comb begin
    tfrm = '1;
    tfrm[0] = 1'b0;
    for (int i = 0; i < 9; i++)
      if (i < 8 || cfg_nine) tfrm[i+1] = hold[i];
    if (cfg_par_en) tfrm[cfg_nine ? 10 : 9] = tpar;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      hold <= '0; hold_full <= 1'b0;
    end else if (tx_valid && !hold_full) begin
      hold <= tx_data; hold_full <= 1'b1;
    end else if (load) hold_full <= 1'b0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tsh <= '1; tleft <= '0; tcnt <= '0; busy <= 1'b0;
    end else if (load) begin
      tsh <= tfrm; tleft <= tlen; tcnt <= '0; busy <= 1'b1;
    end else if (busy && tick) begin
      if (tcnt == LAST) begin
        tcnt  <= '0;
        tsh   <= {1'b1, tsh[12:1]};
        tleft <= tleft - 1'b1;
        if (tleft == 4'd1) busy <= 1'b0;
      end else tcnt <= tcnt + 1'b1;
    end

  assign tbit     = busy ? tsh[0] : 1'b1;
  assign txd      = cfg_half ? 1'b1 : tbit;
  assign sio_o    = tbit;
  assign sio_oe   = cfg_half && busy;
  assign tx_ready = !hold_full;
  assign tx_done  = !hold_full && !busy;

  // receiver
  rx_st_e        rstate;
  logic [CW-1:0] rcnt;
  logic [3:0]    ridx, rlast;
  logic [8:0]    rsh, rword;
  logic          rpar;

  assign rlast = cfg_nine ? 4'd8 : 4'd7;
  assign rword = cfg_nine ? rsh : {1'b0, rsh[7:0]};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rstate <= R_IDLE; rcnt <= '0; ridx <= '0; rsh <= '0; rpar <= 1'b0;
      rx_data <= '0; rx_valid <= 1'b0; rx_perr <= 1'b0; rx_ferr <= 1'b0; rx_ovr <= 1'b0;
    end else begin
      if (rx_rd) begin
        rx_valid <= 1'b0; rx_perr <= 1'b0; rx_ferr <= 1'b0; rx_ovr <= 1'b0;
      end
      case (rstate)
        R_IDLE:
          if (!rx_s) begin rstate <= R_START; rcnt <= '0; end
        R_START:
          if (tick) begin
            if (rcnt == HALF) begin
              rcnt <= '0; ridx <= '0; rsh <= '0;
              rstate <= rx_s ? R_IDLE : R_DATA;
            end else rcnt <= rcnt + 1'b1;
          end
        R_DATA:
          if (tick) begin
            if (rcnt == LAST) begin
              rcnt <= '0;
              rsh[ridx] <= rx_s;
              if (ridx == rlast) rstate <= cfg_par_en ? R_PAR : R_STOP;
              else ridx <= ridx + 1'b1;
            end else rcnt <= rcnt + 1'b1;
          end
        R_PAR:
          if (tick) begin
            if (rcnt == LAST) begin
              rcnt <= '0; rpar <= rx_s; rstate <= R_STOP;
            end else rcnt <= rcnt + 1'b1;
          end
        R_STOP:
          if (tick) begin
            if (rcnt == LAST) begin
              rcnt <= '0;
              rstate <= R_IDLE;
              if (rx_valid && !rx_rd) rx_ovr <= 1'b1;
              else begin
                rx_valid <= 1'b1;
                rx_data  <= rword;
                rx_perr  <= cfg_par_en && (rpar != ((^rword) ^ cfg_par_odd));
                rx_ferr  <= !rx_s;
                rx_ovr   <= 1'b0;
              end
            end else rcnt <= rcnt + 1'b1;
          end
        default: rstate <= R_IDLE;
      endcase
    end

  assign rts_n = rx_valid;
endmodule

module serial_link_fc_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_half,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic       tx_done,
  input logic       rx_valid,
  input logic       rx_rd,
  input logic [8:0] rx_data,
  input logic       rx_ovr,
  input logic       txd,
  input logic       sio_oe,
  input logic       cts_n,
  input logic       rts_n,
  input logic       busy
);
  AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n) tx_done |-> txd && !sio_oe); // R6
  AST_OE_ONLY_HALF: assert property (@(posedge clk) disable iff (!rst_n) sio_oe |-> cfg_half); // R6
  AST_CTS_HOLDS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cts_n && $past(cts_n) && $past(cts_n, 2)) |=> !busy); // R4
  AST_WORD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_rd) |=> rx_valid && rts_n && $stable(rx_data)); // R5
  AST_OVR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_ovr) |-> $past(rx_valid) && !$past(rx_rd)); // R10
  AST_READY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> !tx_ready && !tx_done); // R11
endmodule

bind serial_link_fc serial_link_fc_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_half(cfg_half), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .tx_done(tx_done), .rx_valid(rx_valid), .rx_rd(rx_rd), .rx_data(rx_data), .rx_ovr(rx_ovr),
  .txd(txd), .sio_oe(sio_oe), .cts_n(cts_n), .rts_n(rts_n), .busy(busy)
);

// File: tb/sim_serial_link_fc.sv
module sim_serial_link_fc;
  localparam int CLK_P = 10;
  localparam int NV = 8;
  // {nine, par_en, odd, two_stop, flip_parity, bad_stop, data[8:0]}
  localparam logic [14:0] VEC [NV] = '{
    {6'b000000, 9'h055},
    {6'b010000, 9'h0A7},
    {6'b011100, 9'h03C},
    {6'b100000, 9'h1C3},
    {6'b110100, 9'h0FF},
    {6'b010010, 9'h081},
    {6'b000001, 9'h000},
    {6'b111001, 9'h155}
  };

  logic clk = 0, rst_n = 0;
  logic cfg_nine = 0, cfg_par_en = 0, cfg_par_odd = 0, cfg_two_stop = 0, cfg_half = 0, cfg_ext_tick = 0;
  logic [15:0] cfg_div = 0;
  logic ext_tick = 0;
  logic [8:0] tx_data = 0;
  logic tx_valid = 0, rx_rd = 0, rxd = 1, cts_n = 0, bdrv = 1, bdrv_en = 0;
  logic tx_ready, tx_done, rx_valid, rx_perr, rx_ferr, rx_ovr, txd, sio_o, sio_oe, rts_n;
  logic [8:0] rx_data;
  wire line = sio_oe ? sio_o : (bdrv_en ? bdrv : 1'b1);
  int checks = 0, fails = 0;

  always #(CLK_P/2) clk = ~clk;
  always @(posedge clk) ext_tick <= ~ext_tick;

  serial_link_fc u0 (
    .clk(clk), .rst_n(rst_n), .cfg_nine(cfg_nine), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .cfg_two_stop(cfg_two_stop), .cfg_half(cfg_half), .cfg_ext_tick(cfg_ext_tick), .cfg_div(cfg_div),
    .ext_tick(ext_tick), .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_done(tx_done),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_rd(rx_rd), .rx_perr(rx_perr), .rx_ferr(rx_ferr),
    .rx_ovr(rx_ovr), .txd(txd), .rxd(rxd), .sio_o(sio_o), .sio_oe(sio_oe), .sio_i(line),
    .cts_n(cts_n), .rts_n(rts_n)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  function automatic logic [12:0] mkframe(input logic nine, pe, odd, logic [8:0] d, input logic pflip, fbad);
    logic [12:0] f;
    int k, ones;
    f = '1; f[0] = 1'b0; k = 1; ones = 0;
    for (int i = 0; i < (nine ? 9 : 8); i++) begin
      f[k] = d[i]; if (d[i]) ones++; k++;
    end
    if (pe) begin
      f[k] = ((ones % 2 == 1) ^ odd) ^ pflip; k++;
    end
    if (fbad) f[k] = 1'b0;
    return f;
  endfunction

  function automatic int flen(input logic nine, pe, two);
    return 10 + int'(nine) + int'(pe) + int'(two);
  endfunction

  task automatic push_tx(input logic [8:0] d);
    @(negedge clk);
    while (!tx_ready) @(negedge clk);
    tx_data = d; tx_valid = 1;
    @(negedge clk);
    tx_valid = 0;
  endtask

  task automatic grab(input int bc, input bit from_sio, input int len, output logic [12:0] got);
    int n;
    got = '1; n = 0;
    while ((from_sio ? line : txd) !== 1'b0 && n < 4000) begin @(negedge clk); n++; end
    repeat (bc/2) @(negedge clk);
    for (int i = 0; i < len; i++) begin
      got[i] = from_sio ? line : txd;
      if (i < len - 1) repeat (bc) @(negedge clk);
    end
  endtask

  task automatic send_rx(input logic [12:0] f, input int len, input int bc, input bit to_sio);
    @(negedge clk);
    if (to_sio) bdrv_en = 1;
    for (int i = 0; i < len; i++) begin
      if (to_sio) bdrv = f[i]; else rxd = f[i];
      repeat (bc) @(negedge clk);
    end
    rxd = 1; bdrv = 1; bdrv_en = 0;
    repeat (4) @(negedge clk);
  endtask

  task automatic read_rx();
    @(negedge clk); rx_rd = 1;
    @(negedge clk); rx_rd = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual 1 expected 0");
    finish_run();
  end

  initial begin
    logic [12:0] got, ex;
    int len;
    bit fell;
    repeat (3) @(negedge clk);
    chk(tx_ready === 1 && tx_done === 1, "R1 tx reset", {tx_ready, tx_done}, 3);
    chk(rx_valid === 0 && rts_n === 0, "R1 rx reset", {rx_valid, rts_n}, 0);
    chk(txd === 1 && sio_oe === 0, "R1 line reset", {txd, sio_oe}, 2);
    rst_n = 1;
    repeat (3) @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      logic [14:0] e;
      logic [8:0] xd;
      e = VEC[v];
      cfg_nine = e[14]; cfg_par_en = e[13]; cfg_par_odd = e[12]; cfg_two_stop = e[11];
      len = flen(e[14], e[13], e[11]);
      ex = mkframe(e[14], e[13], e[12], e[8:0], 1'b0, 1'b0);
      push_tx(e[8:0]);
      @(negedge clk);
      chk(tx_ready === 1, "R11 ready after load", tx_ready, 1);
      grab(16, 0, len, got);
      chk(got === ex, "R2 R3 tx frame", got, ex);
      chk(tx_done === 0, "R11 done low in last stop", tx_done, 0);
      repeat (10) @(negedge clk);
      chk(tx_done === 1, "R11 done after frame", tx_done, 1);
      ex = mkframe(e[14], e[13], e[12], e[8:0], e[10], e[9]);
      send_rx(ex, len, 16, 0);
      xd = e[14] ? e[8:0] : {1'b0, e[7:0]};
      chk(rx_valid === 1 && rx_data === xd, "R2 rx data", rx_data, xd);
      chk(rx_perr === e[10], "R3 rx parity flag", rx_perr, e[10]);
      chk(rx_ferr === e[9], "R9 rx framing flag", rx_ferr, e[9]);
      chk(rts_n === 1, "R5 rts high while unread", rts_n, 1);
      read_rx();
      chk(rts_n === 0 && rx_valid === 0 && rx_perr === 0 && rx_ferr === 0, "R5 read clears",
          {rts_n, rx_valid, rx_perr, rx_ferr}, 0);
    end
    cfg_nine = 0; cfg_par_en = 0; cfg_par_odd = 0; cfg_two_stop = 0;

    // CTS held high before frame
    cts_n = 1;
    push_tx(9'h05A);
    fell = 0;
    repeat (200) begin @(negedge clk); if (txd !== 1) fell = 1; end
    chk(!fell && tx_done === 0 && tx_ready === 0, "R4 cts blocks start", {fell, tx_done, tx_ready}, 0);
    cts_n = 0;
    grab(16, 0, 10, got);
    ex = mkframe(0, 0, 0, 9'h05A, 0, 0);
    chk(got === ex, "R4 frame after cts low", got, ex);
    repeat (12) @(negedge clk);

    // CTS raised mid-frame
    push_tx(9'h0C3);
    fork
      grab(16, 0, 10, got);
      begin repeat (40) @(negedge clk); cts_n = 1; end
    join
    ex = mkframe(0, 0, 0, 9'h0C3, 0, 0);
    chk(got === ex, "R4 frame completes", got, ex);
    repeat (12) @(negedge clk);
    chk(tx_done === 1 && txd === 1, "R4 done with cts high", {tx_done, txd}, 3);
    cts_n = 0;

    // overrun
    send_rx(mkframe(0, 0, 0, 9'h011, 0, 0), 10, 16, 0);
    send_rx(mkframe(0, 0, 0, 9'h022, 0, 0), 10, 16, 0);
    chk(rx_ovr === 1 && rx_data === 9'h011, "R10 overrun keeps old", {rx_ovr, rx_data}, {1'b1, 9'h011});
    chk(rts_n === 1, "R5 rts during overrun", rts_n, 1);
    read_rx();
    chk(rx_ovr === 0 && rx_valid === 0, "R10 read clears overrun", {rx_ovr, rx_valid}, 0);

    // start glitch
    @(negedge clk); rxd = 0;
    repeat (4) @(negedge clk); rxd = 1;
    repeat (300) @(negedge clk);
    chk(rx_valid === 0, "R8 glitch rejected", rx_valid, 0);
    send_rx(mkframe(0, 0, 0, 9'h0E1, 0, 0), 10, 16, 0);
    chk(rx_valid === 1 && rx_data === 9'h0E1 && rx_ferr === 0, "R8 frame after glitch", rx_data, 9'h0E1);
    read_rx();

    // half duplex
    cfg_half = 1;
    repeat (3) @(negedge clk);
    chk(sio_oe === 0 && txd === 1, "R6 released when idle", {sio_oe, txd}, 1);
    push_tx(9'h096);
    fork
      grab(16, 1, 10, got);
      begin
        repeat (60) @(negedge clk);
        chk(sio_oe === 1 && txd === 1, "R6 drives shared line", {sio_oe, txd}, 3);
      end
    join
    ex = mkframe(0, 0, 0, 9'h096, 0, 0);
    chk(got === ex, "R6 frame on shared line", got, ex);
    repeat (12) @(negedge clk);
    chk(sio_oe === 0, "R6 released after frame", sio_oe, 0);
    chk(rx_valid === 1 && rx_data === 9'h096, "R7 hears own frame", rx_data, 9'h096);
    read_rx();
    send_rx(mkframe(0, 0, 0, 9'h033, 0, 0), 10, 16, 0);
    chk(rx_valid === 0, "R7 rxd ignored", rx_valid, 0);
    send_rx(mkframe(0, 0, 0, 9'h04B, 0, 0), 10, 16, 1);
    chk(rx_valid === 1 && rx_data === 9'h04B, "R7 rx on shared line", rx_data, 9'h04B);
    read_rx();
    cfg_half = 0;

    // tick sources
    cfg_ext_tick = 1;
    push_tx(9'h06D);
    grab(32, 0, 10, got);
    ex = mkframe(0, 0, 0, 9'h06D, 0, 0);
    chk(got === ex, "R12 external tick tx", got, ex);
    repeat (24) @(negedge clk);
    send_rx(mkframe(0, 0, 0, 9'h0B2, 0, 0), 10, 32, 0);
    chk(rx_valid === 1 && rx_data === 9'h0B2, "R12 external tick rx", rx_data, 9'h0B2);
    read_rx();
    cfg_ext_tick = 0; cfg_div = 2;
    push_tx(9'h0D4);
    grab(48, 0, 10, got);
    ex = mkframe(0, 0, 0, 9'h0D4, 0, 0);
    chk(got === ex, "R12 divider tx", got, ex);
    repeat (30) @(negedge clk);
    cfg_div = 0;

    finish_run();
  end
endmodule